// File: doc/BRIEF.md
# Single-Step 2-D Haar Block Transform

This block computes a two-dimensional Haar wavelet transform on a 2×2 pixel block in one combined add/subtract step. Each accepted block gives the four subband coefficients (average, and the horizontal, vertical and diagonal differences) together. It does not run a row pass followed by a column pass, so no transposition or line storage is needed. The same four-input butterfly also runs in the other direction. In inverse mode, four coefficients go in and the four pixels of the block come back.

A caller presents one block per cycle on four parallel lanes with a valid strobe and a direction bit. Results appear on registered outputs exactly one clock later. A built-in block sequencer walks the block position across an `IMG_N`×`IMG_N` image in raster order of 2×2 blocks. It tags each result with the pixel row and column of the block's top-left corner and pulses a frame-end flag on the last block. The parameter `HALVE` selects one of two scalings: coefficients halved (the normalised Haar pair), or left as raw integer sums that invert exactly.

Top module: `haar2d_engine`

## Requirements
- R1: Forward mode (`dir_inv`=0) with `HALVE`=0: the block's samples are p11 on `lane_a`, p21 on `lane_b`, p12 on `lane_c` and p22 on `lane_d`. Only the low `SAMPLE_W` bits of each lane are used, read as two's complement; the two upper bits are ignored. The outputs are `res_a`=p11+p21+p12+p22, `res_b`=p11−p21+p12−p22, `res_c`=p11+p21−p12−p22 and `res_d`=p11−p21−p12+p22, each a signed `COEF_W`-bit value.
- R2: With `HALVE`=1, each forward output is the R1 sum shifted arithmetically right by one bit, which is floor division by 2.
- R3: Inverse mode (`dir_inv`=1) takes the four lanes in full as signed `COEF_W`-bit coefficients c_a..c_d. It outputs `res_a`=(c_a+c_b+c_c+c_d), `res_b`=(c_a−c_b+c_c−c_d), `res_c`=(c_a+c_b−c_c−c_d) and `res_d`=(c_a−c_b−c_c+c_d). Each is shifted arithmetically right by 2 when `HALVE`=0 and by 1 when `HALVE`=1, then truncated to `COEF_W` bits.
- R4: With `HALVE`=0, feeding the four forward outputs of a block back in inverse mode returns the original four samples exactly.
- R5: `res_valid` is high in the cycle after a cycle with `in_valid` high and low otherwise. The result of a block appears in that same cycle.
- R6: While `res_valid` is low, the result lanes and position tags keep their last values.
- R7: The first block after reset is tagged row 0, column 0. Each accepted block, in either mode, moves the column by 2. After column `IMG_N`−2 the column returns to 0 and the row moves by 2. Tags are always even.
- R8: `frame_end` is high exactly in the result cycle of the block at row `IMG_N`−2, column `IMG_N`−2. The next block is tagged row 0, column 0.
- R9: While `rst` is high and after it is released, before any block is accepted, `res_valid`, `frame_end`, every result lane and both tags are 0.
- R10: Forward raw sums cannot overflow: extreme samples (all most-negative, all most-positive) produce the exact sums in `COEF_W`=`SAMPLE_W`+2 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Block present on the lanes this cycle |
| dir_inv | input | 1 | 0 = forward transform, 1 = inverse |
| lane_a | input | COEF_W | p11 sample or average coefficient |
| lane_b | input | COEF_W | p21 sample or first difference coefficient |
| lane_c | input | COEF_W | p12 sample or second difference coefficient |
| lane_d | input | COEF_W | p22 sample or diagonal coefficient |
| res_valid | output | 1 | Result lanes hold a new block |
| res_a | output | COEF_W | Average coefficient, or p11 |
| res_b | output | COEF_W | First difference coefficient, or p21 |
| res_c | output | COEF_W | Second difference coefficient, or p12 |
| res_d | output | COEF_W | Diagonal coefficient, or p22 |
| res_row | output | POS_W | Pixel row of the block's top-left corner |
| res_col | output | POS_W | Pixel column of the block's top-left corner |
| frame_end | output | 1 | Last block of the image |

## Verification
The datapath keeps no state, so a wrong sign, lane swap or shift shows on the affected result lane in the very cycle after the bad block is accepted. Both direction settings and both scalings are exercised so a swapped inverse route cannot hide. The sequencer does hold state. A column or row register that steps wrongly corrupts the tag of the next block, while a fault in the wrap logic only appears at the end of a row or of the frame. For that reason more than one full frame of blocks is pushed through, and every tag and every `frame_end` value is compared.

// File: rtl/haar2d_pkg.sv
package haar2d_pkg;

    typedef enum logic {
        DIR_FWD = 1'b0,
        DIR_INV = 1'b1
    } dir_e;

    // Arithmetic right shift on a sign-extended integer; floors negative values.
    function automatic int asr(input int v, input int sh);
        return v >>> sh;
    endfunction

    // Right-shift applied after the butterfly, per direction and scaling.
    function automatic int post_shift(input bit halve, input dir_e d);
        if (d == DIR_FWD) return halve ? 1 : 0;
        return halve ? 1 : 2;
    endfunction

endpackage

// File: rtl/haar2d_butterfly.sv
module haar2d_butterfly #(
    parameter int W = 12
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    input  logic signed [W-1:0] op_c,
    input  logic signed [W-1:0] op_d,
    output logic signed [W-1:0] sum_pp,
    output logic signed [W-1:0] sum_mp,
    output logic signed [W-1:0] sum_pm,
    output logic signed [W-1:0] sum_mm
);
    logic signed [W-1:0] pair_sum [2];
    logic signed [W-1:0] pair_dif [2];

    // First stage: two pair butterflies over (a,b) and (c,d).
    for (genvar g = 0; g < 2; g++) begin : g_pair
        logic signed [W-1:0] x, y;
        assign x = (g == 0) ? op_a : op_c;
        assign y = (g == 0) ? op_b : op_d;
        assign pair_sum[g] = x + y;
        assign pair_dif[g] = x - y;
    end

    // Second stage combines the pair results.
    assign sum_pp = pair_sum[0] + pair_sum[1];
    assign sum_mp = pair_dif[0] + pair_dif[1];
    assign sum_pm = pair_sum[0] - pair_sum[1];
    assign sum_mm = pair_dif[0] - pair_dif[1];
endmodule

// File: rtl/haar2d_lane_route.sv
module haar2d_lane_route
    import haar2d_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int COEF_W   = SAMPLE_W + 2,
    parameter int BF_W     = COEF_W + 2,
    parameter bit HALVE    = 1'b0
) (
    input  dir_e                     dir,
    input  logic [COEF_W-1:0]        in_a,
    input  logic [COEF_W-1:0]        in_b,
    input  logic [COEF_W-1:0]        in_c,
    input  logic [COEF_W-1:0]        in_d,
    output logic signed [COEF_W-1:0] out_a,
    output logic signed [COEF_W-1:0] out_b,
    output logic signed [COEF_W-1:0] out_c,
    output logic signed [COEF_W-1:0] out_d
);
    localparam int FWD_SH = post_shift(HALVE, DIR_FWD);
    localparam int INV_SH = post_shift(HALVE, DIR_INV);

    logic signed [BF_W-1:0] ext [4];
    logic signed [BF_W-1:0] op_b, op_c;
    logic signed [BF_W-1:0] s_pp, s_mp, s_pm, s_mm;
    logic [COEF_W-1:0] lanes [4];

    assign lanes[0] = in_a;
    assign lanes[1] = in_b;
    assign lanes[2] = in_c;
    assign lanes[3] = in_d;

    // Sign extension: samples from SAMPLE_W bits, coefficients from COEF_W bits.
    for (genvar i = 0; i < 4; i++) begin : g_ext
        always_comb begin
            if (dir == DIR_FWD)
                ext[i] = {{(BF_W-SAMPLE_W){lanes[i][SAMPLE_W-1]}}, lanes[i][SAMPLE_W-1:0]};
            else
                ext[i] = {{(BF_W-COEF_W){lanes[i][COEF_W-1]}}, lanes[i]};
        end
    end

    // The inverse swaps the middle lanes so the same butterfly rebuilds pixels.
    assign op_b = (dir == DIR_FWD) ? ext[1] : ext[2];
    assign op_c = (dir == DIR_FWD) ? ext[2] : ext[1];

    haar2d_butterfly #(.W(BF_W)) u_bfly (
        .op_a  (ext[0]),
        .op_b  (op_b),
        .op_c  (op_c),
        .op_d  (ext[3]),
        .sum_pp(s_pp),
        .sum_mp(s_mp),
        .sum_pm(s_pm),
        .sum_mm(s_mm)
    );

    always_comb begin
        if (dir == DIR_FWD) begin
            out_a = COEF_W'(asr(int'(s_pp), FWD_SH));
            out_b = COEF_W'(asr(int'(s_mp), FWD_SH));
            out_c = COEF_W'(asr(int'(s_pm), FWD_SH));
            out_d = COEF_W'(asr(int'(s_mm), FWD_SH));
        end else begin
            out_a = COEF_W'(asr(int'(s_pp), INV_SH));
            out_b = COEF_W'(asr(int'(s_pm), INV_SH));
            out_c = COEF_W'(asr(int'(s_mp), INV_SH));
            out_d = COEF_W'(asr(int'(s_mm), INV_SH));
        end
    end
endmodule

// File: rtl/haar2d_block_seq.sv
module haar2d_block_seq #(
    parameter int IMG_N = 8,
    parameter int POS_W = (IMG_N > 2) ? $clog2(IMG_N) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             step,
    output logic [POS_W-1:0] cur_row,
    output logic [POS_W-1:0] cur_col,
    output logic             cur_last
);
    localparam logic [POS_W-1:0] EDGE = POS_W'(IMG_N - 2);

    logic row_end;
    assign row_end  = (cur_col == EDGE);
    assign cur_last = row_end && (cur_row == EDGE);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_row <= '0;
            cur_col <= '0;
        end else if (step) begin
            if (row_end) begin
                cur_col <= '0;
                cur_row <= cur_last ? '0 : cur_row + POS_W'(2);
            end else begin
                cur_col <= cur_col + POS_W'(2);
            end
        end
    end
endmodule

// File: rtl/haar2d_engine.sv
module haar2d_engine
    import haar2d_pkg::*;
#(
    parameter int SAMPLE_W = 8,
    parameter int IMG_N    = 8,
    parameter bit HALVE    = 1'b0,
    parameter int COEF_W   = SAMPLE_W + 2,
    parameter int POS_W    = (IMG_N > 2) ? $clog2(IMG_N) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              in_valid,
    input  logic              dir_inv,
    input  logic [COEF_W-1:0] lane_a,
    input  logic [COEF_W-1:0] lane_b,
    input  logic [COEF_W-1:0] lane_c,
    input  logic [COEF_W-1:0] lane_d,
    output logic              res_valid,
    output logic [COEF_W-1:0] res_a,
    output logic [COEF_W-1:0] res_b,
    output logic [COEF_W-1:0] res_c,
    output logic [COEF_W-1:0] res_d,
    output logic [POS_W-1:0]  res_row,
    output logic [POS_W-1:0]  res_col,
    output logic              frame_end
);
    localparam int BF_W = COEF_W + 2;

    typedef struct packed {
        logic [COEF_W-1:0] a;
        logic [COEF_W-1:0] b;
        logic [COEF_W-1:0] c;
        logic [COEF_W-1:0] d;
    } quad_t;

    typedef struct packed {
        logic [POS_W-1:0] row;
        logic [POS_W-1:0] col;
    } tag_t;

    dir_e  dir;
    quad_t comb_q, held_q;
    tag_t  cur_tag, held_tag;
    logic  seq_last;

    assign dir = dir_e'(dir_inv);

    haar2d_lane_route #(
        .SAMPLE_W(SAMPLE_W),
        .COEF_W  (COEF_W),
        .BF_W    (BF_W),
        .HALVE   (HALVE)
    ) u_route (
        .dir  (dir),
        .in_a (lane_a),
        .in_b (lane_b),
        .in_c (lane_c),
        .in_d (lane_d),
        .out_a(comb_q.a),
        .out_b(comb_q.b),
        .out_c(comb_q.c),
        .out_d(comb_q.d)
    );

    haar2d_block_seq #(.IMG_N(IMG_N), .POS_W(POS_W)) u_seq (
        .clk     (clk),
        .rst     (rst),
        .step    (in_valid),
        .cur_row (cur_tag.row),
        .cur_col (cur_tag.col),
        .cur_last(seq_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            frame_end <= 1'b0;
            held_q    <= '0;
            held_tag  <= '0;
        end else begin
            res_valid <= in_valid;
            frame_end <= in_valid && seq_last;
            if (in_valid) begin
                held_q   <= comb_q;
                held_tag <= cur_tag;
            end
        end
    end

    assign res_a   = held_q.a;
    assign res_b   = held_q.b;
    assign res_c   = held_q.c;
    assign res_d   = held_q.d;
    assign res_row = held_tag.row;
    assign res_col = held_tag.col;
endmodule

// File: rtl/haar2d_engine_chk.sv
module haar2d_engine_chk #(
    parameter int IMG_N  = 8,
    parameter int COEF_W = 10,
    parameter int POS_W  = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              in_valid,
    input logic              res_valid,
    input logic [COEF_W-1:0] res_a,
    input logic [COEF_W-1:0] res_b,
    input logic [COEF_W-1:0] res_c,
    input logic [COEF_W-1:0] res_d,
    input logic [POS_W-1:0]  res_row,
    input logic [POS_W-1:0]  res_col,
    input logic              frame_end
);
    localparam logic [POS_W-1:0] EDGE = POS_W'(IMG_N - 2);

    p_latency_r5: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> res_valid);

    p_no_spurious_r5: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !res_valid);

    p_hold_lanes_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_a) && $stable(res_b) && $stable(res_c) && $stable(res_d)));

    p_hold_tags_r6: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(res_row) && $stable(res_col)));

    p_even_tag_r7: assert property (@(posedge clk) disable iff (rst)
        res_valid |-> (res_row[0] == 1'b0 && res_col[0] == 1'b0));

    p_end_on_last_r8: assert property (@(posedge clk) disable iff (rst)
        frame_end |-> (res_valid && res_row == EDGE && res_col == EDGE));

    p_last_flags_end_r8: assert property (@(posedge clk) disable iff (rst)
        (res_valid && res_row == EDGE && res_col == EDGE) |-> frame_end);
endmodule

bind haar2d_engine haar2d_engine_chk #(
    .IMG_N (IMG_N),
    .COEF_W(COEF_W),
    .POS_W (POS_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_valid (in_valid),
    .res_valid(res_valid),
    .res_a    (res_a),
    .res_b    (res_b),
    .res_c    (res_c),
    .res_d    (res_d),
    .res_row  (res_row),
    .res_col  (res_col),
    .frame_end(frame_end)
);

// File: tb/haar2d_engine_bench.sv
`timescale 1ns/1ps
module haar2d_engine_bench;
    localparam int SW = 8;
    localparam int CW = SW + 2;
    localparam int N  = 8;
    localparam int PW = 3;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic dir_inv = 1'b0;
    logic [CW-1:0] lane_a = '0, lane_b = '0, lane_c = '0, lane_d = '0;

    logic          rv_r, rv_h, fe_r, fe_h;
    logic [CW-1:0] ra_r, rb_r, rc_r, rd_r, ra_h, rb_h, rc_h, rd_h;
    logic [PW-1:0] row_r, col_r, row_h, col_h;

    always #2.5 clk = ~clk;

    haar2d_engine #(.SAMPLE_W(SW), .IMG_N(N), .HALVE(1'b0)) u_haar2d_engine (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dir_inv(dir_inv),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .lane_d(lane_d),
        .res_valid(rv_r), .res_a(ra_r), .res_b(rb_r), .res_c(rc_r), .res_d(rd_r),
        .res_row(row_r), .res_col(col_r), .frame_end(fe_r));

    haar2d_engine #(.SAMPLE_W(SW), .IMG_N(N), .HALVE(1'b1)) u_haar2d_engine_half (
        .clk(clk), .rst(rst), .in_valid(in_valid), .dir_inv(dir_inv),
        .lane_a(lane_a), .lane_b(lane_b), .lane_c(lane_c), .lane_d(lane_d),
        .res_valid(rv_h), .res_a(ra_h), .res_b(rb_h), .res_c(rc_h), .res_d(rd_h),
        .res_row(row_h), .res_col(col_h), .frame_end(fe_h));

    typedef struct {
        int    raw [4];
        int    half [4];
        int    row;
        int    col;
        bit    last;
        string tag;
    } item_t;

    item_t exp_q [$];
    int vectors = 0;
    int misses  = 0;
    int seq_row = 0;
    int seq_col = 0;

    task automatic check(input string tag, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            misses++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int s_samp(input logic [CW-1:0] v);
        return int'($signed(v[SW-1:0]));
    endfunction

    function automatic int s_coef(input logic [CW-1:0] v);
        return int'($signed(v));
    endfunction

    function automatic int wrap(input int v);
        logic [CW-1:0] t;
        t = CW'(v);
        return int'($signed(t));
    endfunction

    // Expected values straight from the R1..R3 formulas.
    function automatic void model(input bit inv, input int x [4], input int sh,
                                  output int y [4]);
        if (!inv) begin
            y[0] = wrap((x[0] + x[1] + x[2] + x[3]) >>> sh);
            y[1] = wrap((x[0] - x[1] + x[2] - x[3]) >>> sh);
            y[2] = wrap((x[0] + x[1] - x[2] - x[3]) >>> sh);
            y[3] = wrap((x[0] - x[1] - x[2] + x[3]) >>> sh);
        end else begin
            y[0] = wrap((x[0] + x[1] + x[2] + x[3]) >>> sh);
            y[1] = wrap((x[0] - x[1] + x[2] - x[3]) >>> sh);
            y[2] = wrap((x[0] + x[1] - x[2] - x[3]) >>> sh);
            y[3] = wrap((x[0] - x[1] - x[2] + x[3]) >>> sh);
        end
    endfunction

    task automatic send(input bit inv, input int a, input int b, input int c,
                        input int d, input string tag);
        item_t it;
        int x [4];
        @(negedge clk);
        in_valid = 1'b1;
        dir_inv  = inv;
        lane_a = CW'(a); lane_b = CW'(b); lane_c = CW'(c); lane_d = CW'(d);
        if (!inv) begin
            x[0] = s_samp(lane_a); x[1] = s_samp(lane_b);
            x[2] = s_samp(lane_c); x[3] = s_samp(lane_d);
        end else begin
            x[0] = s_coef(lane_a); x[1] = s_coef(lane_b);
            x[2] = s_coef(lane_c); x[3] = s_coef(lane_d);
        end
        model(inv, x, inv ? 2 : 0, it.raw);
        model(inv, x, 1, it.half);
        it.row  = seq_row;
        it.col  = seq_col;
        it.last = (seq_row == N - 2) && (seq_col == N - 2);
        it.tag  = tag;
        exp_q.push_back(it);
        if (seq_col == N - 2) begin
            seq_col = 0;
            seq_row = it.last ? 0 : seq_row + 2;
        end else begin
            seq_col = seq_col + 2;
        end
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        in_valid = 1'b0;
        lane_a = CW'(77); lane_b = CW'(-5); lane_c = CW'(300); lane_d = CW'(1);
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pops one expected item per result cycle, else checks hold.
    logic [CW-1:0] prev_r [4];
    logic [CW-1:0] prev_h [4];
    logic [PW-1:0] prev_row, prev_col;
    bit mon_en = 1'b0;

    always @(negedge clk) begin
        if (mon_en) begin
            if (rv_r) begin
                if (exp_q.size() == 0) begin
                    check("R5 unexpected result", 1, 0);
                end else begin
                    item_t e;
                    e = exp_q.pop_front();
                    check({e.tag, " raw a"}, s_coef(ra_r), e.raw[0]);
                    check({e.tag, " raw b"}, s_coef(rb_r), e.raw[1]);
                    check({e.tag, " raw c"}, s_coef(rc_r), e.raw[2]);
                    check({e.tag, " raw d"}, s_coef(rd_r), e.raw[3]);
                    check({e.tag, " R2 half a"}, s_coef(ra_h), e.half[0]);
                    check({e.tag, " R2 half b"}, s_coef(rb_h), e.half[1]);
                    check({e.tag, " R2 half c"}, s_coef(rc_h), e.half[2]);
                    check({e.tag, " R2 half d"}, s_coef(rd_h), e.half[3]);
                    check("R7 row tag", int'(row_r), e.row);
                    check("R7 col tag", int'(col_r), e.col);
                    check("R7 row tag half", int'(row_h), e.row);
                    check("R8 frame_end", int'(fe_r), int'(e.last));
                    check("R8 frame_end half", int'(fe_h), int'(e.last));
                    check("R5 valid half", int'(rv_h), 1);
                end
            end else begin
                check("R5 valid half idle", int'(rv_h), 0);
                check("R8 frame_end idle", int'(fe_r), 0);
                check("R6 hold a", int'(ra_r), int'(prev_r[0]));
                check("R6 hold d", int'(rd_r), int'(prev_r[3]));
                check("R6 hold half b", int'(rb_h), int'(prev_h[1]));
                check("R6 hold row", int'(row_r), int'(prev_row));
                check("R6 hold col", int'(col_r), int'(prev_col));
            end
        end
        prev_r[0] = ra_r; prev_r[1] = rb_r; prev_r[2] = rc_r; prev_r[3] = rd_r;
        prev_h[0] = ra_h; prev_h[1] = rb_h; prev_h[2] = rc_h; prev_h[3] = rd_h;
        prev_row = row_r; prev_col = col_r;
    end

    task automatic reset_checks(input string when);
        check({"R9 valid ", when}, int'(rv_r), 0);
        check({"R9 frame_end ", when}, int'(fe_r), 0);
        check({"R9 lanes ", when}, int'(ra_r | rb_r | rc_r | rd_r), 0);
        check({"R9 half lanes ", when}, int'(ra_h | rb_h | rc_h | rd_h), 0);
        check({"R9 tags ", when}, int'(row_r | col_r), 0);
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        misses++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        reset_checks("in reset");
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        reset_checks("after release");
        mon_en = 1'b1;

        send(1'b0, 10, 20, 30, 40, "R1 basic");
        send(1'b0, -128, 127, -1, 0, "R1 mixed signs");
        idle(3);
        send(1'b0, 127, 127, 127, 127, "R10 max");
        send(1'b0, -128, -128, -128, -128, "R10 min");
        send(1'b0, 'h301, 'h2FF, 'h17F, 'h280, "R1 upper bits ignored");
        send(1'b0, 3, 0, 0, 0, "R2 odd sum");
        idle(2);
        begin
            int px [4];
            int cf [4];
            px[0] = 5; px[1] = -7; px[2] = 100; px[3] = -128;
            model(1'b0, px, 0, cf);
            send(1'b0, px[0], px[1], px[2], px[3], "R1 roundtrip fwd");
            send(1'b1, cf[0], cf[1], cf[2], cf[3], "R4 roundtrip inv");
        end
        send(1'b1, 3, 1, -2, 7, "R3 inverse floor");
        send(1'b1, -512, -512, -512, -512, "R3 inverse extreme");
        idle(4);
        for (int i = 0; i < 22; i++) begin
            send(i[0], i * 13 - 90, 60 - i * 7, i * i - 50, -i * 5, "R7 frame sweep");
            if (i % 5 == 4) idle(1 + i % 3);
        end
        idle(5);
        check("R5 queue drained", exp_q.size(), 0);
        finish_run();
    end
endmodule